// File: doc/BRIEF.md
# Serial LED Indicator Pattern Shifter

This block holds the indicator state for a bank of drive slots, three bits per slot: activity, locate and fault. On an update request it decodes a 32-bit status word into the three indicator bits of one port, writes them at the LED position to which that port is mapped, and then sends the whole pattern to an external LED controller over three wires: a serial clock, a load strobe and a data line.

A frame starts with a configurable number of dummy clocks. One clock follows with the load strobe high. The data bits come next, least significant first, three per active slot. The frame closes with a configurable number of trailing clocks. Each serial clock is high for a parameterised number of system cycles and then low for the same number. The block is busy while a frame runs, and requests that arrive then are dropped. A request whose slot field is out of range is refused: it sends nothing and changes nothing.

Top module: `sgpio_led_serializer`

## Requirements
- R1: An accepted update decodes the status word as follows. Activity = bit 20 OR bit 21, locate = bit 19, fault = bit 22. Each bit is written as 1 when its condition is true and as 0 otherwise. Bits that belong to other positions are left unchanged.
- R2: Port `p` maps to position `pos_map[3p+2:3p]`. Its activity, locate and fault bits are pattern bits 3·pos+0, 3·pos+1 and 3·pos+2.
- R3: At the falling edge of each serial clock a frame shows the following, in order. First, `pre_clks` clocks with load=0 and data=0. Then one clock with load=1 and data=0. Then 3·min(`act_slots`, NUM_SLOTS) clocks with load=0, carrying pattern bits 0, 1, 2 and upward. Last, `post_clks` clocks with load=0 and data=0.
- R4: Inside a frame, each serial clock is high for exactly HALF_CYC system cycles and then low for exactly HALF_CYC cycles.
- R5: While not busy, `sclk`, `sload` and `sdata` are all 1. After reset, `busy`, `done` and `reject` are all 0.
- R6: `busy` goes high in the cycle after an accepted request and stays high for 2·HALF_CYC·(pre+1+bits+post) cycles. `done` is high for exactly the one cycle after `busy` falls.
- R7: A request made while `busy` is high has no effect on the pattern or on the frame in progress.
- R8: A request whose slot field, status bits [15:8], is at or above SLOT_LIMIT (default 8) raises `reject` for one cycle. It starts no frame and leaves the pattern unchanged. A slot value of SLOT_LIMIT−1 is accepted.
- R9: With `pre_clks`=0 the load clock is the first clock of the frame. With `act_slots`=0 no data clocks are sent. `act_slots` values above NUM_SLOTS are treated as NUM_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Update request, sampled each cycle |
| port_sel | input | 3 | Port whose indicators are updated |
| status | input | 32 | Status word: indicator bits and slot field |
| pos_map | input | 24 | LED position of each port, 3 bits per port |
| act_slots | input | 4 | Number of slots sent per frame |
| pre_clks | input | 8 | Dummy clocks before the load clock |
| post_clks | input | 8 | Trailing clocks after the data |
| sclk | output | 1 | Serial clock, idles high |
| sload | output | 1 | Load strobe, idles high |
| sdata | output | 1 | Serial data, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame ends |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
Requests are driven on the falling system edge and are accepted at the next rising edge. `reject` is therefore due at the next falling-edge sample, and `busy` is high from that sample on. The frame length is checked by counting the falling-edge samples with `busy` high against 2·HALF_CYC·(pre+1+bits+post). `done` is expected at the first sample after that count, and the lines must be back at idle one sample later. Load and data are captured only at the falling edges of the serial clock, where they hold for the whole clock, so each captured bit is compared with the bench's own pattern model, independent of the phase offset.

// File: rtl/sled_pkg.sv
package sled_pkg;
   localparam int IND_BITS = 3;
   localparam int SLOT_LSB = 8;
   localparam int SLOT_W   = 8;

   typedef enum logic [2:0] {
      PH_IDLE, PH_PRE, PH_LOAD, PH_DATA, PH_POST
   } phase_t;

   // act lands at offset 0, locate at 1, fault at 2 within a slot
   typedef struct packed {
      logic fault;
      logic locate;
      logic act;
   } ind_t;

   function automatic ind_t decode_ind(input logic [31:0] s);
      ind_t r;
      r.act    = s[20] | s[21];
      r.locate = s[19];
      r.fault  = s[22];
      return r;
   endfunction
endpackage

// File: rtl/sled_pattern.sv
module sled_pattern
   import sled_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int POS_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   parameter int PAT_W     = IND_BITS * NUM_SLOTS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd,
   input  logic [POS_W-1:0]           port_sel,
   input  logic [31:0]                status,
   input  logic [NUM_SLOTS*POS_W-1:0] pos_map,
   input  logic                       busy,
   output logic [PAT_W-1:0]           pattern
);
   logic [POS_W-1:0] pos;
   ind_t             nv;

   assign pos = pos_map[int'(port_sel)*POS_W +: POS_W];
   assign nv  = decode_ind(status);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      ind_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (upd && (pos == POS_W'(i)))
            slot_q <= nv;
      end
      assign pattern[IND_BITS*i +: IND_BITS] = slot_q;
   end

   // R7
   pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(pattern));
endmodule

// File: rtl/sled_halfclk.sv
module sled_halfclk #(
   parameter int HALF_CYC = 4,
   parameter int CW       = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic hi_half,
   output logic clk_end
);
   logic [CW-1:0] hcnt;
   logic          ph;
   logic          last;

   if (HALF_CYC < 1) begin : g_bad_half
      $error("HALF_CYC must be at least 1");
   end

   assign last    = (hcnt == CW'(HALF_CYC - 1));
   assign hi_half = !ph;
   assign clk_end = run && ph && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         ph   <= 1'b0;
      end else if (start) begin
         hcnt <= '0;
         ph   <= 1'b0;
      end else if (run) begin
         if (last) begin
            hcnt <= '0;
            ph   <= !ph;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sled_frame.sv
module sled_frame
   import sled_pkg::*;
#(
   parameter int PAT_W = 24,
   parameter int CNT_W = 8,
   parameter int NB_W  = 5,
   parameter int RW    = (CNT_W > NB_W) ? CNT_W : NB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] pre,
   input  logic [CNT_W-1:0] post,
   input  logic [NB_W-1:0]  nbits,
   input  logic [PAT_W-1:0] pattern,
   input  logic             hi_half,
   input  logic             clk_end,
   output logic             busy,
   output logic             done,
   output logic             sclk,
   output logic             sload,
   output logic             sdata
);
   phase_t           phase;
   logic [RW-1:0]    rem;
   logic [CNT_W-1:0] post_q;
   logic [NB_W-1:0]  nbits_q;
   logic [PAT_W-1:0] sh;

   assign busy  = (phase != PH_IDLE);
   assign sclk  = busy ? hi_half : 1'b1;
   assign sload = busy ? (phase == PH_LOAD) : 1'b1;
   assign sdata = busy ? ((phase == PH_DATA) && sh[0]) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         rem     <= '0;
         post_q  <= '0;
         nbits_q <= '0;
         sh      <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            post_q  <= post;
            nbits_q <= nbits;
            if (pre != '0) begin
               phase <= PH_PRE;
               rem   <= RW'(pre);
            end else begin
               phase <= PH_LOAD;
               rem   <= RW'(1);
            end
         end else if (clk_end) begin
            unique case (phase)
               PH_PRE: begin
                  if (rem == RW'(1)) phase <= PH_LOAD;
                  else               rem   <= rem - 1'b1;
               end
               PH_LOAD: begin
                  sh <= pattern;
                  if (nbits_q != '0) begin
                     phase <= PH_DATA;
                     rem   <= RW'(nbits_q);
                  end else if (post_q != '0) begin
                     phase <= PH_POST;
                     rem   <= RW'(post_q);
                  end else begin
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                  end
               end
               PH_DATA: begin
                  sh <= sh >> 1;
                  if (rem == RW'(1)) begin
                     if (post_q != '0) begin
                        phase <= PH_POST;
                        rem   <= RW'(post_q);
                     end else begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                     end
                  end else begin
                     rem <= rem - 1'b1;
                  end
               end
               PH_POST: begin
                  if (rem == RW'(1)) begin
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                  end else begin
                     rem <= rem - 1'b1;
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R6
   fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: rtl/sgpio_led_serializer.sv
module sgpio_led_serializer
   import sled_pkg::*;
#(
   parameter int NUM_SLOTS  = 8,
   parameter int HALF_CYC   = 4,
   parameter int CNT_W      = 8,
   parameter int SLOT_LIMIT = 8,
   parameter int POS_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   parameter int AW         = $clog2(NUM_SLOTS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req,
   input  logic [POS_W-1:0]           port_sel,
   input  logic [31:0]                status,
   input  logic [NUM_SLOTS*POS_W-1:0] pos_map,
   input  logic [AW-1:0]              act_slots,
   input  logic [CNT_W-1:0]           pre_clks,
   input  logic [CNT_W-1:0]           post_clks,
   output logic                       sclk,
   output logic                       sload,
   output logic                       sdata,
   output logic                       busy,
   output logic                       done,
   output logic                       reject
);
   localparam int PAT_W = IND_BITS * NUM_SLOTS;
   localparam int NB_W  = $clog2(PAT_W + 1);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 2");
   end
   if (SLOT_LIMIT < 1 || SLOT_LIMIT > 255) begin : g_bad_limit
      $error("SLOT_LIMIT must lie in 1..255");
   end

   logic             go, slot_ok, upd;
   logic [AW-1:0]    act_c;
   logic [NB_W-1:0]  nbits;
   logic [PAT_W-1:0] pattern;
   logic             hi_half, clk_end;

   assign go      = req && !busy;
   assign slot_ok = status[SLOT_LSB +: SLOT_W] < SLOT_W'(SLOT_LIMIT);
   assign upd     = go && slot_ok;
   assign act_c   = (act_slots > AW'(NUM_SLOTS)) ? AW'(NUM_SLOTS) : act_slots;
   assign nbits   = NB_W'(IND_BITS * int'(act_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reject <= 1'b0;
      else        reject <= go && !slot_ok;
   end

   sled_pattern #(.NUM_SLOTS(NUM_SLOTS), .POS_W(POS_W), .PAT_W(PAT_W)) u_pat (
      .clk(clk), .rst_n(rst_n), .upd(upd), .port_sel(port_sel),
      .status(status), .pos_map(pos_map), .busy(busy), .pattern(pattern)
   );

   sled_halfclk #(.HALF_CYC(HALF_CYC)) u_half (
      .clk(clk), .rst_n(rst_n), .start(upd), .run(busy),
      .hi_half(hi_half), .clk_end(clk_end)
   );

   sled_frame #(.PAT_W(PAT_W), .CNT_W(CNT_W), .NB_W(NB_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .start(upd), .pre(pre_clks),
      .post(post_clks), .nbits(nbits), .pattern(pattern),
      .hi_half(hi_half), .clk_end(clk_end), .busy(busy), .done(done),
      .sclk(sclk), .sload(sload), .sdata(sdata)
   );

   // R5
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk && sload && sdata));
   // R8
   reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> !busy);
endmodule

// File: tb/tb_sgpio_led_serializer.sv
module tb_sgpio_led_serializer;
   localparam int H  = 4;
   localparam int NV = 7;

   logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0;
   logic [2:0]  port_sel = '0;
   logic [31:0] status = '0;
   logic [23:0] pos_map;
   logic [3:0]  act_slots = 4'd8;
   logic [7:0]  pre_clks = '0, post_clks = '0;
   logic        sclk, sload, sdata, busy, done, reject;

   sgpio_led_serializer dut (
      .clk(clk), .rst_n(rst_n), .req(req), .port_sel(port_sel),
      .status(status), .pos_map(pos_map), .act_slots(act_slots),
      .pre_clks(pre_clks), .post_clks(post_clks), .sclk(sclk),
      .sload(sload), .sdata(sdata), .busy(busy), .done(done),
      .reject(reject)
   );

   always #2 clk = !clk;

   // {port, status, pre, post, act_slots}
   localparam logic [54:0] VEC [NV] = '{
      {3'd0, 32'h0010_0000, 8'd0, 8'd0, 4'd8},
      {3'd3, 32'h0060_0000, 8'd2, 8'd1, 4'd8},
      {3'd7, 32'h0008_0000, 8'd0, 8'd3, 4'd8},
      {3'd5, 32'h0058_0000, 8'd1, 8'd0, 4'd4},
      {3'd3, 32'h0000_0000, 8'd0, 8'd0, 4'd8},
      {3'd2, 32'h0040_0000, 8'd3, 8'd2, 4'd0},
      {3'd1, 32'h0010_0000, 8'd0, 8'd0, 4'd15}
   };

   int n_cmp = 0, n_bad = 0;
   logic [23:0] exp_pat = '0;

   logic cap_load [64];
   logic cap_data [64];
   int   ncap = 0, busy_cnt = 0, run = 0;
   bit   tbad = 0, prev_busy = 0, prev_sclk = 1;

   function automatic int pos_of(input int p);
      return (p * 3 + 1) % 8;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic model(input int p, input logic [31:0] s);
      int b;
      b = 3 * pos_of(p);
      exp_pat[b]   = s[20] | s[21];
      exp_pat[b+1] = s[19];
      exp_pat[b+2] = s[22];
   endtask

   always @(negedge clk) begin
      if (busy) begin
         busy_cnt++;
         if (prev_busy && prev_sclk && !sclk && ncap < 64) begin
            cap_load[ncap] = sload;
            cap_data[ncap] = sdata;
            ncap++;
         end
         if (prev_busy && (sclk == prev_sclk)) run++;
         else begin
            if (prev_busy && run != H) tbad = 1;
            run = 1;
         end
      end else if (prev_busy) begin
         if (run != H) tbad = 1;
      end
      prev_busy = busy;
      prev_sclk = sclk;
   end

   task automatic kick(input int p, input logic [31:0] s, input int pre, input int post, input int act);
      @(negedge clk);
      ncap = 0; busy_cnt = 0; tbad = 0;
      port_sel = 3'(p); status = s; pre_clks = 8'(pre);
      post_clks = 8'(post); act_slots = 4'(act); req = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic finish(input int pre, input int post, input int act, input string tag);
      int nb, n, waitc, bad_i, ea, ed;
      bit seen;
      nb = 3 * ((act > 8) ? 8 : act);
      n  = pre + 1 + nb + post;
      seen = 0; waitc = 0;
      while (!seen && waitc < 4000) begin
         if (done) seen = 1;
         else begin @(negedge clk); waitc++; end
      end
      chk(seen, "R6 done pulse seen", int'(seen), 1);
      @(negedge clk);
      chk(!done && sclk && sload && sdata, "R5/R6 idle lines and single done",
          int'({done, sclk, sload, sdata}), 7);
      chk(busy_cnt == 2 * H * n, "R6 busy length", busy_cnt, 2 * H * n);
      chk(!tbad, "R4 half period length", int'(tbad), 0);
      bad_i = -1;
      if (ncap != n) bad_i = 99;
      else
         for (int i = 0; i < n; i++) begin
            ea = (i == pre) ? 1 : 0;
            ed = (i > pre && i <= pre + nb) ? int'(exp_pat[i - pre - 1]) : 0;
            if (bad_i < 0 && (int'(cap_load[i]) != ea || int'(cap_data[i]) != ed)) bad_i = i;
         end
      chk(bad_i < 0, tag, ncap, n);
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int p = 0; p < 8; p++) pos_map[3*p +: 3] = 3'(pos_of(p));
      repeat (3) @(negedge clk);
      chk(sclk && sload && sdata, "R5 reset lines", int'({sclk, sload, sdata}), 7);
      chk(!busy && !done && !reject, "R5 reset flags", int'({busy, done, reject}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table: R1 R2 R3 R9 under several patterns
      for (int v = 0; v < NV; v++) begin
         logic [54:0] e;
         e = VEC[v];
         kick(int'(e[54:52]), e[51:20], int'(e[19:12]), int'(e[11:4]), int'(e[3:0]));
         model(int'(e[54:52]), e[51:20]);
         finish(int'(e[19:12]), int'(e[11:4]), int'(e[3:0]), "R1/R2/R3/R9 frame bits");
      end

      // R8: out-of-range slot refused
      @(negedge clk);
      port_sel = 3'd0; status = 32'h0040_0800; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(reject == 1'b1, "R8 reject pulse", int'(reject), 1);
      chk(busy == 1'b0, "R8 no frame", int'(busy), 0);
      begin
         int bseen;
         bseen = 0;
         @(negedge clk);
         chk(reject == 1'b0, "R8 reject one cycle", int'(reject), 0);
         repeat (20) begin @(negedge clk); if (busy) bseen++; end
         chk(bseen == 0, "R8 stays idle", bseen, 0);
      end
      // R8 boundary: slot 7 accepted
      kick(2, 32'h0030_0700, 0, 0, 8);
      model(2, 32'h0030_0700);
      chk(reject == 1'b0, "R8 slot limit-1 accepted", int'(reject), 0);
      finish(0, 0, 8, "R8 pattern unchanged by reject");

      // R7: request during frame ignored
      kick(6, 32'h0040_0000, 0, 1, 8);
      model(6, 32'h0040_0000);
      repeat (10) @(negedge clk);
      port_sel = 3'd4; status = 32'h0048_0000; act_slots = 4'd2; req = 1'b1;
      @(negedge clk);
      req = 1'b0; act_slots = 4'd8;
      chk(reject == 1'b0 && busy, "R7 busy holds off", int'({reject, busy}), 1);
      finish(0, 1, 8, "R7 frame undisturbed");
      kick(0, 32'h0020_0000, 1, 0, 8);
      model(0, 32'h0020_0000);
      finish(1, 0, 8, "R7 ignored request left pattern");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule